// File: doc/BRIEF.md
# SDRAM Init and Refresh Sequencer

This controller-side block takes a four-bank SDRAM from power-up to an operational state and then keeps the array refreshed. It drives the clock-enable and command pins, the bank-address pins and the address bus. After reset it holds the command bus at NOP for the power-up interval. It then issues a precharge of every bank, a programmable number of auto-refresh commands and a mode-register write. When enabled, it follows that with an extended-mode-register write. Each step waits a cycle count that is derived at elaboration from the clock period and the minimum time in nanoseconds, rounded up.

Once the sequence finishes, a `ready` flag rises and stays high. A free-running interval counter then requests one auto-refresh per slot of the refresh window. A user-side pulse can ask for an extra refresh. Requests are counted while the block is busy, or while the data path reports that some bank is still open. Each queued request is issued as soon as all banks are idle and the previous refresh has had its row-cycle time. The mode-register values come in as configuration inputs.

Top module: `sdram_init_refresh`

## Requirements
- R1: During reset and for `ceil(PWRUP_NS/CLK_NS)` clock edges after its release, the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `cke` is 1 and `ready` is 0. The first command appears after exactly that edge.
- R2: The first command is a precharge of all banks: pins 0010, address bit 10 high, every other address bit 0, bank address 00.
- R3: `INIT_REFS` auto-refresh commands (pins 0001, address 0) follow. The first comes `ceil(TRP_NS/CLK_NS)` cycles after the precharge, and the rest are spaced `ceil(TRC_NS/CLK_NS)` cycles apart.
- R4: `ceil(TRC_NS/CLK_NS)` cycles after the last initial refresh, a mode-register write (pins 0000, bank address 00, address = `cfg_mode`) is issued. The pins stay NOP for the cycle after it.
- R5: When `cfg_ext_en` is 1, an extended-mode write follows 2 cycles after the mode write. It uses pins 0000 and bank address 10, with address bits 2:0 = `cfg_pasr`, bit 5 = `cfg_ds` and every other bit 0. When `cfg_ext_en` is 0, no such write is issued.
- R6: `ready` rises 2 cycles after the last mode write and then stays high until reset.
- R7: After `ready`, periodic auto-refreshes are spaced `floor(floor(REF_WINDOW_NS/REF_COUNT)/CLK_NS)` cycles apart. The first one comes that many cycles plus 1 after `ready` rises.
- R8: No auto-refresh is issued while `banks_idle` is 0. Periodic requests that fall due meanwhile are counted, up to `PEND_MAX`. After `banks_idle` returns to 1, they are issued one clock later, spaced the row-cycle time apart.
- R9: A one-cycle pulse on `user_ref_req` adds one refresh. If the block is idle, the refresh appears on the pins one cycle after the edge that samples the pulse. During a refresh it is issued exactly the row-cycle time after that refresh.
- R10: `busy` is 1 from reset through init and during each refresh's row-cycle time. It is 0 when the block is idle with nothing to issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | ADDR_W | Mode-register value placed on the address bus |
| cfg_ext_en | input | 1 | Issue the extended-mode write during init |
| cfg_pasr | input | 3 | Refreshed-region select for the extended-mode write |
| cfg_ds | input | 1 | Drive-strength select for the extended-mode write |
| banks_idle | input | 1 | All banks are precharged (from the data path) |
| user_ref_req | input | 1 | One-cycle request for an extra auto-refresh |
| cke | output | 1 | Clock enable to the SDRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | Init sequence complete |
| busy | output | 1 | Sequencer owns the command bus |

## Verification
The bench builds the block with an 8 ns clock and the standard 18 ns and 63 ns minimums, which give 3-cycle and 8-cycle waits. It shortens the power-up interval to 800 ns, or 100 cycles, so that several full init sequences fit in one run. The refresh window is set so the periodic interval is 50 cycles. That makes it practical to watch consecutive refreshes and to hold `banks_idle` low across three due slots, which builds a backlog of three. User pulses are placed both inside a refresh and in an idle gap to exercise both serving paths.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE = 4'b0000,
        CMD_AREF = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_NOP  = 4'b0111
    } cmd_e;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_PRE,
        ST_INITREF,
        ST_MODE,
        ST_EXTMODE,
        ST_IDLE,
        ST_REF
    } state_e;

    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_cmd_pins.sv
module sdram_cmd_pins
    import sdram_seq_pkg::*;
(
    input  cmd_e cmd,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = cmd;
    end
endmodule

// File: rtl/sdram_ref_tracker.sv
module sdram_ref_tracker #(
    parameter int INT_CYC  = 976,
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic user_req,
    input  logic pop,
    output logic due
);
    localparam int CNT_W  = $clog2(INT_CYC + 1);
    localparam int PEND_W = $clog2(PEND_MAX + 1);
    localparam int SUM_W  = PEND_W + 2;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [PEND_W-1:0] pend;
    } trk_t;

    trk_t q, n;
    logic tick;
    logic [SUM_W-1:0] sum;

    always_comb begin
        n    = q;
        tick = en && (q.cnt == CNT_W'(INT_CYC - 1));
        if (!en || tick) n.cnt = '0;
        else             n.cnt = q.cnt + 1'b1;
        sum = SUM_W'(q.pend) + SUM_W'(tick) + SUM_W'(user_req) - SUM_W'(pop);
        if (sum > SUM_W'(PEND_MAX)) n.pend = PEND_W'(PEND_MAX);
        else                        n.pend = sum[PEND_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign due = (q.pend != '0);

    // a due interval slot with no other traffic raises the backlog by one
    assert_tick_counted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pop && !user_req && (q.pend < PEND_W'(PEND_MAX)))
            |=> (q.pend == $past(q.pend) + 1'b1));

    // a pop never happens on an empty backlog
    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (q.pend != '0));
endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
    import sdram_seq_pkg::*;
#(
    parameter int CLK_NS        = 8,
    parameter int PWRUP_NS      = 200000,
    parameter int TRP_NS        = 18,
    parameter int TRC_NS        = 63,
    parameter int MRD_CYC       = 2,
    parameter int INIT_REFS     = 2,
    parameter int REF_WINDOW_NS = 64000000,
    parameter int REF_COUNT     = 8192,
    parameter int PEND_MAX      = 8,
    parameter int ADDR_W        = 13,
    parameter int BA_W          = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_mode,
    input  logic              cfg_ext_en,
    input  logic [2:0]        cfg_pasr,
    input  logic              cfg_ds,
    input  logic              banks_idle,
    input  logic              user_ref_req,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready,
    output logic              busy
);
    localparam int PWRUP_CYC = ns_to_cycles(PWRUP_NS, CLK_NS);
    localparam int TRP_CYC   = ns_to_cycles(TRP_NS, CLK_NS);
    localparam int TRC_CYC   = ns_to_cycles(TRC_NS, CLK_NS);
    localparam int MRD_EFF   = max_of(MRD_CYC, 2);
    localparam int REF_INT   = max_of((REF_WINDOW_NS / REF_COUNT) / CLK_NS, 1);
    localparam int WAIT_MAX  = max_of(max_of(PWRUP_CYC, TRP_CYC), max_of(TRC_CYC, MRD_EFF));
    localparam int WAIT_W    = $clog2(WAIT_MAX + 1);
    localparam int RCNT_W    = $clog2(INIT_REFS + 1);
    localparam int AP_BIT    = 10;

    typedef struct packed {
        state_e            state;
        logic [WAIT_W-1:0] wait_cnt;
        logic [RCNT_W-1:0] ref_cnt;
        cmd_e              cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              ready;
    } seq_t;

    seq_t q, n;
    logic ref_due;
    logic pop;
    logic [ADDR_W-1:0] ext_word;

    always_comb begin
        ext_word      = '0;
        ext_word[2:0] = cfg_pasr;
        ext_word[5]   = cfg_ds;
    end

    always_comb begin
        n      = q;
        n.cmd  = CMD_NOP;
        n.ba   = '0;
        n.addr = '0;
        pop    = 1'b0;
        case (q.state)
            ST_PWRUP: begin
                if (q.wait_cnt == '0) begin
                    n.state        = ST_PRE;
                    n.cmd          = CMD_PRE;
                    n.addr[AP_BIT] = 1'b1;
                    n.wait_cnt     = WAIT_W'(TRP_CYC - 1);
                end else n.wait_cnt = q.wait_cnt - 1'b1;
            end
            ST_PRE: begin
                if (q.wait_cnt == '0) begin
                    n.state    = ST_INITREF;
                    n.cmd      = CMD_AREF;
                    n.ref_cnt  = RCNT_W'(1);
                    n.wait_cnt = WAIT_W'(TRC_CYC - 1);
                end else n.wait_cnt = q.wait_cnt - 1'b1;
            end
            ST_INITREF: begin
                if (q.wait_cnt == '0) begin
                    if (q.ref_cnt < RCNT_W'(INIT_REFS)) begin
                        n.cmd      = CMD_AREF;
                        n.ref_cnt  = q.ref_cnt + 1'b1;
                        n.wait_cnt = WAIT_W'(TRC_CYC - 1);
                    end else begin
                        n.state    = ST_MODE;
                        n.cmd      = CMD_MODE;
                        n.addr     = cfg_mode;
                        n.wait_cnt = WAIT_W'(MRD_EFF - 1);
                    end
                end else n.wait_cnt = q.wait_cnt - 1'b1;
            end
            ST_MODE: begin
                if (q.wait_cnt == '0) begin
                    if (cfg_ext_en) begin
                        n.state    = ST_EXTMODE;
                        n.cmd      = CMD_MODE;
                        n.ba       = BA_W'(2);
                        n.addr     = ext_word;
                        n.wait_cnt = WAIT_W'(MRD_EFF - 1);
                    end else begin
                        n.state = ST_IDLE;
                        n.ready = 1'b1;
                    end
                end else n.wait_cnt = q.wait_cnt - 1'b1;
            end
            ST_EXTMODE: begin
                if (q.wait_cnt == '0) begin
                    n.state = ST_IDLE;
                    n.ready = 1'b1;
                end else n.wait_cnt = q.wait_cnt - 1'b1;
            end
            default: begin // ST_IDLE, ST_REF
                if (q.state == ST_IDLE || q.wait_cnt == '0) begin
                    if (ref_due && banks_idle) begin
                        n.state    = ST_REF;
                        n.cmd      = CMD_AREF;
                        n.wait_cnt = WAIT_W'(TRC_CYC - 1);
                        pop        = 1'b1;
                    end else n.state = ST_IDLE;
                end else n.wait_cnt = q.wait_cnt - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state    <= ST_PWRUP;
            q.wait_cnt <= WAIT_W'(PWRUP_CYC - 1);
            q.ref_cnt  <= '0;
            q.cmd      <= CMD_NOP;
            q.ba       <= '0;
            q.addr     <= '0;
            q.ready    <= 1'b0;
        end else begin
            q <= n;
        end
    end

    sdram_ref_tracker #(
        .INT_CYC  (REF_INT),
        .PEND_MAX (PEND_MAX)
    ) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (q.ready),
        .user_req (user_ref_req),
        .pop      (pop),
        .due      (ref_due)
    );

    sdram_cmd_pins u_pins (
        .cmd   (q.cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n)
    );

    assign cke   = 1'b1;
    assign ba    = q.ba;
    assign addr  = q.addr;
    assign ready = q.ready;
    assign busy  = (q.state != ST_IDLE);

    // a mode write is followed by at least one quiet cycle
    assert_mode_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_MODE) |=> (q.cmd == CMD_NOP));

    // the extended write only ever follows a normal mode write
    assert_ext_after_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_MODE && q.ba == BA_W'(2))
            |-> ($past(q.cmd, 2) == CMD_MODE && $past(q.ba, 2) == '0));

    // ready is sticky
    assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.ready |=> q.ready);

    // runtime refresh only when the data path reported all banks idle
    assert_refresh_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_AREF && q.ready) |-> $past(banks_idle));

    // the bus is free only after init is complete
    assert_idle_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> q.ready);
endmodule

// File: tb/sdram_init_refresh_bench.sv
module sdram_init_refresh_bench;
    localparam int CLK_NS = 8, PWRUP_NS = 800, TRP_NS = 18, TRC_NS = 63;
    localparam int INIT_REFS = 2, REF_WINDOW_NS = 3276800, REF_COUNT = 8192;

    function automatic int up_div(int ns, int c);
        return (ns + c - 1) / c;
    endfunction
    function automatic logic [12:0] ext_word(logic [2:0] p, logic d);
        logic [12:0] w;
        w = '0; w[2:0] = p; w[5] = d;
        return w;
    endfunction

    localparam int E_PWR = (PWRUP_NS + CLK_NS - 1) / CLK_NS;
    localparam int E_TRP = (TRP_NS + CLK_NS - 1) / CLK_NS;
    localparam int E_TRC = (TRC_NS + CLK_NS - 1) / CLK_NS;
    localparam int E_INT = (REF_WINDOW_NS / REF_COUNT) / CLK_NS;

    logic clk = 0, rst_n = 0;
    logic [12:0] cfg_mode = '0;
    logic cfg_ext_en = 0, cfg_ds = 0, banks_idle = 1, user_ref_req = 0;
    logic [2:0] cfg_pasr = '0;
    logic cke, cs_n, ras_n, cas_n, we_n, ready, busy;
    logic [1:0] ba;
    logic [12:0] addr;
    int cyc = 0, checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always_ff @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    sdram_init_refresh #(
        .CLK_NS(CLK_NS), .PWRUP_NS(PWRUP_NS), .TRP_NS(TRP_NS), .TRC_NS(TRC_NS),
        .MRD_CYC(2), .INIT_REFS(INIT_REFS), .REF_WINDOW_NS(REF_WINDOW_NS),
        .REF_COUNT(REF_COUNT), .PEND_MAX(8), .ADDR_W(13), .BA_W(2)
    ) u_sdram_init_refresh (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_ext_en(cfg_ext_en),
        .cfg_pasr(cfg_pasr), .cfg_ds(cfg_ds), .banks_idle(banks_idle),
        .user_ref_req(user_ref_req), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .ready(ready), .busy(busy)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [3:0] pins();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic next_cmd(output logic [3:0] c, output int at);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (pins() == 4'b0111 && n < 5000);
        c = pins();
        at = cyc;
    endtask

    task automatic run_init(bit ext, logic [12:0] mode, logic [2:0] pasr, bit ds, output int t);
        logic [3:0] c;
        int at;
        rst_n = 0; cfg_ext_en = ext; cfg_mode = mode; cfg_pasr = pasr; cfg_ds = ds;
        banks_idle = 1; user_ref_req = 0;
        repeat (3) @(negedge clk);
        chk(pins() == 4'b0111 && cke && !ready, "R1 reset state", int'(pins()), 7);
        chk(busy == 1'b1, "R10 busy in reset", int'(busy), 1);
        rst_n = 1;
        next_cmd(c, at);
        chk(c == 4'b0010 && at == E_PWR, "R1 power-up wait", at, E_PWR);
        chk(addr == 13'h0400 && ba == 2'b00 && !ready, "R2 precharge all", int'(addr), 'h400);
        t = at;
        next_cmd(c, at);
        chk(c == 4'b0001 && at == t + E_TRP && addr == 0, "R3 first init refresh", at, t + E_TRP);
        t = at;
        for (int i = 1; i < INIT_REFS; i++) begin
            next_cmd(c, at);
            chk(c == 4'b0001 && at == t + E_TRC, "R3 init refresh spacing", at, t + E_TRC);
            t = at;
        end
        next_cmd(c, at);
        chk(c == 4'b0000 && at == t + E_TRC && ba == 2'b00, "R4 mode write timing", at, t + E_TRC);
        chk(addr == mode, "R4 mode value", int'(addr), int'(mode));
        t = at;
        @(negedge clk);
        chk(pins() == 4'b0111, "R4 quiet after mode", int'(pins()), 7);
        if (ext) begin
            next_cmd(c, at);
            chk(c == 4'b0000 && ba == 2'b10 && at == t + 2, "R5 ext write", at, t + 2);
            chk(addr == ext_word(pasr, ds), "R5 ext value", int'(addr), int'(ext_word(pasr, ds)));
            t = at;
            @(negedge clk);
        end
        chk(ready == 1'b0, "R6 ready low before", int'(ready), 0);
        @(negedge clk);
        chk(ready == 1'b1, "R6 ready rise", int'(ready), 1);
    endtask

    initial begin
        logic [3:0] c;
        int at, t, a, quiet;
        void'($urandom(32'h5D0E1));
        run_init(1'b1, 13'h0032, 3'b001, 1'b1, t);
        for (int k = 0; k < 4; k++) begin
            run_init(1'($urandom % 2), 13'($urandom), 3'($urandom % 3), 1'($urandom % 2), t);
        end
        run_init(1'b0, 13'($urandom), 3'b010, 1'b0, t);
        // t = cycle of the mode write; ready at t+2
        next_cmd(c, at);
        chk(c == 4'b0001 && at == t + 2 + E_INT + 1, "R7 R5 first periodic refresh", at, t + 3 + E_INT);
        t = at;
        next_cmd(c, at);
        chk(c == 4'b0001 && at == t + E_INT, "R7 periodic spacing", at, t + E_INT);
        a = at;
        banks_idle = 0;
        quiet = 0;
        while (cyc < a + 160) begin
            @(negedge clk);
            if (pins() != 4'b0111) quiet++;
        end
        chk(quiet == 0, "R8 no refresh while banks busy", quiet, 0);
        banks_idle = 1;
        for (int i = 0; i < 3; i++) begin
            next_cmd(c, at);
            chk(c == 4'b0001 && at == a + 161 + i * E_TRC, "R8 backlog drain", at, a + 161 + i * E_TRC);
        end
        next_cmd(c, at);
        chk(c == 4'b0001 && at == a + 200, "R7 periodic after backlog", at, a + 200);
        user_ref_req = 1;
        @(negedge clk);
        user_ref_req = 0;
        next_cmd(c, at);
        chk(c == 4'b0001 && at == a + 200 + E_TRC, "R9 request during refresh", at, a + 200 + E_TRC);
        while (cyc < at + E_TRC - 1) @(negedge clk);
        chk(busy == 1'b1, "R10 busy during row cycle", int'(busy), 1);
        @(negedge clk);
        chk(busy == 1'b0, "R10 idle after row cycle", int'(busy), 0);
        next_cmd(c, at);
        chk(c == 4'b0001 && at == a + 250, "R7 periodic resumes", at, a + 250);
        while (cyc < a + 260) @(negedge clk);
        user_ref_req = 1;
        @(negedge clk);
        user_ref_req = 0;
        next_cmd(c, at);
        chk(c == 4'b0001 && at == a + 262, "R9 request while idle", at, a + 262);
        next_cmd(c, at);
        chk(c == 4'b0001 && at == a + 300, "R7 periodic after request", at, a + 300);
        chk(ready == 1'b1 && cke == 1'b1, "R6 ready held", int'(ready), 1);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule